// File: doc/BRIEF.md
# Bi-phase Load-Modulation Packet Transmitter

This block lets a wireless-power receiver talk to its transmitter. It drives a single load-modulation switch so that the coil current on the transmitter side carries packets. Bits are sent at 2 kbps with differential bi-phase coding. A tick input at twice the bit rate (4 kHz) paces all timing: one tick per half bit.

After reset the block runs a fixed start-up order of three packets: signal strength, then configuration, then identification. It then sends control-error packets on a timer. The period is long (1000 ticks, 250 ms) while the system is settled. It is short (128 ticks, 32 ms) while the caller raises a fast-update flag. An end-power-transfer request with a reason byte overtakes any other pending work. Once that packet has gone out, the block stays silent until the next reset.

While a packet is on the line, a communication-active output is high. The output regulator uses it to clamp load current, so that load steps cannot be mistaken for modulation. Payload bytes are taken from input registers at the moment a packet is launched.

Top module: `bpm_packet_tx`

## Requirements
- R1: During reset and in the first cycle after it, mod_drive and comm_active are 0. After reset, busy is 1 while start-up packets are still owed.
- R2: Every bit begins with a toggle of mod_drive. A one-bit has one extra toggle at mid-bit; a zero-bit has none. mod_drive changes only on a clock edge where tick_2x is high.
- R3: Every packet opens with exactly PREAMBLE_BITS one-bits (default 11), followed by the first start bit.
- R4: Each byte goes out as 11 bits in this order: a 0 start bit, 8 data bits least significant first, a parity bit that makes the count of ones over data and parity odd, and a 1 stop bit.
- R5: The last byte of a packet is a checksum. XOR-ed together with the header and every message byte, it gives 0.
- R6: The first three packets after reset are sent in this order:
  - header 0x01 with the 1-byte sig_value;
  - header 0x51 with 5 bytes;
  - header 0x71 with 7 bytes.
  Message byte i of a multi-byte field is bits [8i+7:8i] of cfg_msg or id_msg, and byte 0 is sent first.
- R7: After start-up, control-error packets (header 0x03, message ce_value) start every SLOW_TICKS ticks (default 1000) while fast_req is low.
- R8: While fast_req is high, control-error packets start every FAST_TICKS ticks (default 128). The period returns to SLOW_TICKS once fast_req falls.
- R9: A pulse on ept_req causes an end-power-transfer packet: header 0x02 with ept_reason as its single message byte. If the request comes before the first packet, this packet is sent instead of the start-up sequence.
- R10: After an end-power-transfer packet, no further packet is sent and busy stays 0. Further ept_req pulses have no effect until reset.
- R11: comm_active is high from the launch tick until the last half-bit of the packet. While it is low, mod_drive does not change. A packet always begins on a tick.
- R12: A request that arrives while a packet is on the line is held. When that packet ends, a pending end-power-transfer packet is sent next, ahead of any remaining start-up or control-error packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_2x | input | 1 | One-cycle pulse at twice the bit rate (half-bit tick) |
| sig_value | input | 8 | Signal-strength message byte |
| cfg_msg | input | 40 | Configuration message, byte 0 in bits [7:0] |
| id_msg | input | 56 | Identification message, byte 0 in bits [7:0] |
| ce_value | input | 8 | Control-error message byte |
| fast_req | input | 1 | Level: use the short control-error period |
| ept_req | input | 1 | Pulse: request an end-power-transfer packet |
| ept_reason | input | 8 | Reason code, captured with ept_req |
| mod_drive | output | 1 | Load-modulation switch drive |
| busy | output | 1 | A packet is on the line or owed |
| comm_active | output | 1 | High for the whole duration of a packet |

## Verification
The bench decodes the line itself from samples taken after each tick. It checks boundary toggles, preamble length, byte framing, parity and checksum on each packet type. This covers message lengths of 1, 5 and 7 bytes with different bit patterns, so that errors in ordering, parity sense or bit order show up. Cadence is checked by counting ticks between packet starts: once with fast_req steady low, once steady high, and once after it falls. This separates the two periods from the counter-restart behaviour. End-power-transfer is tried twice: requested before any packet, and requested in the middle of the first packet. The first shows the start-up sequence is skipped. The second shows the request is queued and ranks above the remaining start-up packets. A long silent window afterwards, with a further request, confirms the halt.

// File: rtl/bpm_pkg.sv
// Package: shared constants and types of the bi-phase packet transmitter.
// Assumes messages never exceed MSG_MAX bytes.
package bpm_pkg;
    localparam int MSG_MAX   = 8;
    localparam int LEN_W     = 4;
    localparam int BYTE_BITS = 8;
    localparam int FRAME_LEN = BYTE_BITS + 3;

    localparam logic [7:0] HDR_SIG = 8'h01;
    localparam logic [7:0] HDR_CFG = 8'h51;
    localparam logic [7:0] HDR_ID  = 8'h71;
    localparam logic [7:0] HDR_CE  = 8'h03;
    localparam logic [7:0] HDR_EPT = 8'h02;

    typedef enum logic [2:0] {
        SEQ_SIG, SEQ_CFG, SEQ_ID, SEQ_RUN, SEQ_HALT
    } seq_e;

    typedef enum logic [1:0] {
        FR_IDLE, FR_PRE, FR_BYTE
    } fr_e;

    typedef struct packed {
        logic [7:0]               hdr;
        logic [LEN_W-1:0]         len;
        logic [MSG_MAX*8-1:0]     msg;
    } pkt_t;
endpackage

// File: rtl/bpm_scheduler.sv
// Scheduler: picks the next packet and launches it on a tick when the framer
// is idle. Order of precedence: end-power-transfer, start-up sequence,
// control-error. Keeps the control-error cadence counter in half-bit ticks.
// Assumes tick is a one-cycle pulse and fr_busy comes from the framer.
module bpm_scheduler
    import bpm_pkg::*;
#(
    parameter int SLOW_TICKS = 1000,
    parameter int FAST_TICKS = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        fr_busy,
    input  logic [7:0]  sig_value,
    input  logic [39:0] cfg_msg,
    input  logic [55:0] id_msg,
    input  logic [7:0]  ce_value,
    input  logic        fast_req,
    input  logic        ept_req,
    input  logic [7:0]  ept_reason,
    output logic        launch,
    output pkt_t        pkt,
    output logic        pending
);
    localparam int MAXP  = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CNT_W = $clog2(MAXP + 1);

    seq_e             seq_q;
    logic             ept_pend_q;
    logic [7:0]       reason_q;
    logic             ce_due_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic             in_startup;
    logic             ce_sent;

    // Purpose: decode whether the sequencer still owes start-up packets.
    always_comb begin
        in_startup = (seq_q == SEQ_SIG) || (seq_q == SEQ_CFG) || (seq_q == SEQ_ID);
    end

    // Purpose: flag owed work and launch it on a tick when the framer is free.
    always_comb begin
        pending = (seq_q != SEQ_HALT) &&
                  (ept_pend_q || in_startup || ((seq_q == SEQ_RUN) && ce_due_q));
        launch  = tick && !fr_busy && pending;
        ce_sent = launch && !ept_pend_q && (seq_q == SEQ_RUN);
        period  = fast_req ? CNT_W'(FAST_TICKS - 1) : CNT_W'(SLOW_TICKS - 1);
    end

    // Purpose: assemble header, length and message of the packet to launch.
    always_comb begin
        pkt = '0;
        if (ept_pend_q) begin
            pkt.hdr      = HDR_EPT;
            pkt.len      = LEN_W'(1);
            pkt.msg[7:0] = reason_q;
        end else begin
            case (seq_q)
                SEQ_SIG: begin
                    pkt.hdr      = HDR_SIG;
                    pkt.len      = LEN_W'(1);
                    pkt.msg[7:0] = sig_value;
                end
                SEQ_CFG: begin
                    pkt.hdr       = HDR_CFG;
                    pkt.len       = LEN_W'(5);
                    pkt.msg[39:0] = cfg_msg;
                end
                SEQ_ID: begin
                    pkt.hdr       = HDR_ID;
                    pkt.len       = LEN_W'(7);
                    pkt.msg[55:0] = id_msg;
                end
                default: begin
                    pkt.hdr      = HDR_CE;
                    pkt.len      = LEN_W'(1);
                    pkt.msg[7:0] = ce_value;
                end
            endcase
        end
    end

    // Purpose: advance the start-up sequence and enter halt after a shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_SIG;
        end else if (launch) begin
            if (ept_pend_q) begin
                seq_q <= SEQ_HALT;
            end else begin
                case (seq_q)
                    SEQ_SIG: seq_q <= SEQ_CFG;
                    SEQ_CFG: seq_q <= SEQ_ID;
                    SEQ_ID:  seq_q <= SEQ_RUN;
                    default: seq_q <= seq_q;
                endcase
            end
        end
    end

    // Purpose: hold one end-power-transfer request and its reason code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ept_pend_q <= 1'b0;
            reason_q   <= '0;
        end else if (seq_q == SEQ_HALT) begin
            ept_pend_q <= 1'b0;
        end else if (ept_req) begin
            ept_pend_q <= 1'b1;
            reason_q   <= ept_reason;
        end else if (launch) begin
            ept_pend_q <= 1'b0;
        end
    end

    // Purpose: count ticks and mark a control-error packet as due each period.
    always_ff @(posedge clk) begin
        if (!rst_n || (seq_q != SEQ_RUN)) begin
            cnt_q    <= '0;
            ce_due_q <= 1'b0;
        end else begin
            if (ce_sent) begin
                ce_due_q <= 1'b0;
            end
            if (tick) begin
                if (cnt_q >= period) begin
                    cnt_q    <= '0;
                    ce_due_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bpm_framer.sv
// Framer: serialises one packet as preamble ones, then header, message and
// checksum bytes, each framed as start, 8 data bits LSB first, odd parity,
// stop. Presents the current bit and moves on when the encoder reports the
// bit finished. Assumes launch arrives only while idle.
module bpm_framer
    import bpm_pkg::*;
#(
    parameter int PREAMBLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  pkt_t pkt,
    input  logic bit_done,
    output logic busy,
    output logic bit_val
);
    localparam int PRE_W = $clog2(PREAMBLE_BITS + 1);
    localparam int POS_W = $clog2(FRAME_LEN);

    fr_e                  state_q;
    logic [PRE_W-1:0]     pre_q;
    logic [POS_W-1:0]     pos_q;
    logic [LEN_W-1:0]     idx_q;
    logic [7:0]           hdr_q;
    logic [LEN_W-1:0]     len_q;
    logic [MSG_MAX*8-1:0] msg_q;
    logic [7:0]           chk_q;
    logic [7:0]           chk_new;
    logic [7:0]           cur;
    logic                 last_byte;

    // Purpose: checksum of the packet being launched, unused bytes ignored.
    always_comb begin
        chk_new = pkt.hdr;
        for (int i = 0; i < MSG_MAX; i++) begin
            if (LEN_W'(i) < pkt.len) begin
                chk_new = chk_new ^ pkt.msg[8*i +: 8];
            end
        end
    end

    // Purpose: select the byte under transmission.
    always_comb begin
        cur = hdr_q;
        for (int i = 0; i < MSG_MAX; i++) begin
            if (idx_q == LEN_W'(i + 1)) begin
                cur = msg_q[8*i +: 8];
            end
        end
        last_byte = (idx_q == len_q + LEN_W'(1));
        if (last_byte) begin
            cur = chk_q;
        end
    end

    // Purpose: map the frame position onto the bit value on offer.
    always_comb begin
        bit_val = 1'b1;
        if (state_q == FR_BYTE) begin
            if (pos_q == POS_W'(0)) begin
                bit_val = 1'b0;
            end else if (pos_q == POS_W'(FRAME_LEN - 2)) begin
                bit_val = ~^cur;
            end else if (pos_q == POS_W'(FRAME_LEN - 1)) begin
                bit_val = 1'b1;
            end else begin
                bit_val = cur[3'(pos_q - POS_W'(1))];
            end
        end
        busy = (state_q != FR_IDLE);
    end

    // Purpose: latch the packet and step through preamble and byte frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            pre_q   <= '0;
            pos_q   <= '0;
            idx_q   <= '0;
            hdr_q   <= '0;
            len_q   <= '0;
            msg_q   <= '0;
            chk_q   <= '0;
        end else begin
            case (state_q)
                FR_IDLE: begin
                    if (launch) begin
                        state_q <= FR_PRE;
                        pre_q   <= '0;
                        hdr_q   <= pkt.hdr;
                        len_q   <= pkt.len;
                        msg_q   <= pkt.msg;
                        chk_q   <= chk_new;
                    end
                end
                FR_PRE: begin
                    if (bit_done) begin
                        if (pre_q == PRE_W'(PREAMBLE_BITS - 1)) begin
                            state_q <= FR_BYTE;
                            pos_q   <= '0;
                            idx_q   <= '0;
                        end else begin
                            pre_q <= pre_q + PRE_W'(1);
                        end
                    end
                end
                default: begin
                    if (bit_done) begin
                        if (pos_q == POS_W'(FRAME_LEN - 1)) begin
                            pos_q <= '0;
                            if (last_byte) begin
                                state_q <= FR_IDLE;
                            end else begin
                                idx_q <= idx_q + LEN_W'(1);
                            end
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bpm_encoder.sv
// Encoder: differential bi-phase line coder. On each tick while active it
// toggles the line at the bit boundary, and toggles again at mid-bit when
// the bit is one. Assumes bit_in is stable for the two halves of a bit.
module bpm_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic bit_in,
    output logic line,
    output logic bit_done
);
    logic phase_q;
    logic line_q;

    // Purpose: mark the tick that completes the second half of a bit.
    always_comb begin
        bit_done = tick && active && phase_q;
        line     = line_q;
    end

    // Purpose: drive the line level and track the half-bit phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            line_q  <= 1'b0;
        end else if (!active) begin
            phase_q <= 1'b0;
        end else if (tick) begin
            if (!phase_q) begin
                line_q  <= ~line_q;
                phase_q <= 1'b1;
            end else begin
                if (bit_in) begin
                    line_q <= ~line_q;
                end
                phase_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bpm_packet_tx.sv
// Top: packet transmitter for a wireless-power receiver. Connects the
// scheduler, framer and bi-phase encoder. comm_active follows the framer so
// the load limit covers every half-bit of a packet. Assumes tick_2x is a
// one-cycle pulse at twice the bit rate.
module bpm_packet_tx
    import bpm_pkg::*;
#(
    parameter int SLOW_TICKS    = 1000,
    parameter int FAST_TICKS    = 128,
    parameter int PREAMBLE_BITS = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_2x,
    input  logic [7:0]  sig_value,
    input  logic [39:0] cfg_msg,
    input  logic [55:0] id_msg,
    input  logic [7:0]  ce_value,
    input  logic        fast_req,
    input  logic        ept_req,
    input  logic [7:0]  ept_reason,
    output logic        mod_drive,
    output logic        busy,
    output logic        comm_active
);
    logic launch;
    pkt_t pkt;
    logic sched_pending;
    logic fr_busy;
    logic bit_val;
    logic bit_done;

    bpm_scheduler #(
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_2x),
        .fr_busy    (fr_busy),
        .sig_value  (sig_value),
        .cfg_msg    (cfg_msg),
        .id_msg     (id_msg),
        .ce_value   (ce_value),
        .fast_req   (fast_req),
        .ept_req    (ept_req),
        .ept_reason (ept_reason),
        .launch     (launch),
        .pkt        (pkt),
        .pending    (sched_pending)
    );

    bpm_framer #(
        .PREAMBLE_BITS (PREAMBLE_BITS)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .pkt      (pkt),
        .bit_done (bit_done),
        .busy     (fr_busy),
        .bit_val  (bit_val)
    );

    bpm_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_2x),
        .active   (fr_busy),
        .bit_in   (bit_val),
        .line     (mod_drive),
        .bit_done (bit_done)
    );

    // Purpose: combine in-flight and owed work into the external flags.
    always_comb begin
        comm_active = fr_busy;
        busy        = fr_busy || sched_pending;
    end
endmodule

// File: rtl/bpm_packet_tx_chk.sv
// Checker: temporal properties of the transmitter ports, bound to the top.
module bpm_packet_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_2x,
    input logic mod_drive,
    input logic busy,
    input logic comm_active
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mod_drive && !comm_active)); // R1

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_2x |=> $stable(mod_drive)); // R2

    AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        !comm_active |=> $stable(mod_drive)); // R11

    AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        comm_active |-> busy); // R11

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comm_active) |-> $past(tick_2x)); // R11
endmodule

bind bpm_packet_tx bpm_packet_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_2x     (tick_2x),
    .mod_drive   (mod_drive),
    .busy        (busy),
    .comm_active (comm_active)
);

// File: tb/bpm_packet_tx_bench.sv
module bpm_packet_tx_bench;
    localparam int SLOW = 1000;
    localparam int FAST = 128;
    localparam int PRE  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_2x = 1'b0;
    logic [7:0]  sig_value = 8'hA5;
    logic [39:0] cfg_msg = 40'h13_57_9B_DF_02;
    logic [55:0] id_msg = 56'h01_23_45_67_89_AB_CD;
    logic [7:0]  ce_value = 8'h7E;
    logic        fast_req = 1'b0;
    logic        ept_req = 1'b0;
    logic [7:0]  ept_reason = 8'h00;
    logic        mod_drive;
    logic        busy;
    logic        comm_active;

    int checks = 0;
    int errors = 0;
    int tick_no = 0;
    int rise_tick = 0;
    int quiet_viol = 0;
    logic hv [0:511];
    bit   bits [0:255];
    logic [7:0] pb [0:15];
    int nh;
    int npb;
    logic lvl0;
    logic prev_mod;
    logic prev_act;

    bpm_packet_tx u_bpm_packet_tx (
        .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .sig_value(sig_value),
        .cfg_msg(cfg_msg), .id_msg(id_msg), .ce_value(ce_value),
        .fast_req(fast_req), .ept_req(ept_req), .ept_reason(ept_reason),
        .mod_drive(mod_drive), .busy(busy), .comm_active(comm_active)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R11 monitor: line may change only if comm_active was high before.
    always @(negedge clk) begin
        if (rst_n && prev_act === 1'b0 && mod_drive !== prev_mod) quiet_viol++;
        prev_mod = mod_drive;
        prev_act = comm_active;
    end

    task automatic do_tick();
        @(negedge clk) tick_2x = 1'b1;
        @(negedge clk) tick_2x = 1'b0;
        tick_no++;
    endtask

    task automatic pulse_ept(input logic [7:0] r);
        @(negedge clk) begin ept_req = 1'b1; ept_reason = r; end
        @(negedge clk) ept_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ept_req = 1'b0; fast_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for a packet, record every half-bit, decode and check framing.
    task automatic capture(input int max_wait, input string tag);
        int w = 0;
        int nbits, viol, p, rem, ferr;
        logic [7:0] x;
        while (!comm_active && w < max_wait) begin do_tick(); w++; end
        lvl0 = mod_drive;
        npb = 0;
        if (!comm_active) begin
            check(1'b0, "R11", {tag, " packet start"}, 0, 1);
            return;
        end
        rise_tick = tick_no;
        nh = 0;
        while (comm_active && nh < 512) begin
            do_tick();
            hv[nh] = mod_drive;
            nh++;
        end
        nbits = nh / 2;
        viol = 0;
        for (int i = 0; i < nbits; i++) begin
            if (hv[2*i] === ((i == 0) ? lvl0 : hv[2*i-1])) viol++;
            bits[i] = (hv[2*i] !== hv[2*i+1]);
        end
        check(viol == 0 && (nh % 2) == 0, "R2", {tag, " boundary toggles"}, viol, 0);
        p = 0;
        while (p < nbits && bits[p]) p++;
        check(p == PRE, "R3", {tag, " preamble length"}, p, PRE);
        rem = nbits - p;
        check(rem > 0 && (rem % 11) == 0, "R4", {tag, " frame bit count"}, rem, 33);
        ferr = 0;
        npb = rem / 11;
        for (int k = 0; k < npb && k < 16; k++) begin
            int b = p + 11 * k;
            int ones = 0;
            if (bits[b] != 1'b0) ferr++;
            for (int j = 0; j < 8; j++) begin
                pb[k][j] = bits[b+1+j];
                ones += bits[b+1+j];
            end
            ones += bits[b+9];
            if ((ones % 2) != 1) ferr++;
            if (bits[b+10] != 1'b1) ferr++;
        end
        check(ferr == 0, "R4", {tag, " start/parity/stop"}, ferr, 0);
        x = 8'h00;
        for (int k = 0; k < npb && k < 16; k++) x ^= pb[k];
        check(x == 8'h00, "R5", {tag, " checksum"}, x, 0);
    endtask

    task automatic expect_pkt(input logic [7:0] hdr, input int len,
                              input logic [63:0] msg, input string req, input string tag);
        int bad = 0;
        check(npb == len + 2, req, {tag, " byte count"}, npb, len + 2);
        check(pb[0] == hdr, req, {tag, " header"}, pb[0], hdr);
        for (int i = 0; i < len && i < 14; i++) if (pb[i+1] != msg[8*i +: 8]) bad++;
        check(bad == 0, req, {tag, " message bytes"}, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mod_drive == 1'b0 && comm_active == 1'b0, "R1", "outputs in reset",
              {mod_drive, comm_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1 && comm_active == 1'b0, "R1", "busy owed after reset",
              {busy, comm_active}, 2);
    endtask

    task automatic t_startup_and_slow();
        int r1;
        capture(20, "sig");
        expect_pkt(8'h01, 1, {56'h0, sig_value}, "R6", "first=sig");
        capture(20, "cfg");
        expect_pkt(8'h51, 5, {24'h0, cfg_msg}, "R6", "second=cfg");
        capture(20, "id");
        expect_pkt(8'h71, 7, {8'h0, id_msg}, "R6", "third=id");
        capture(SLOW + 50, "ce1");
        expect_pkt(8'h03, 1, {56'h0, ce_value}, "R7", "ce header");
        r1 = rise_tick;
        ce_value = 8'h81;
        capture(SLOW + 50, "ce2");
        expect_pkt(8'h03, 1, {56'h0, 8'h81}, "R7", "ce new value");
        check(rise_tick - r1 == SLOW, "R7", "slow interval", rise_tick - r1, SLOW);
    endtask

    task automatic t_fast();
        int r1;
        fast_req = 1'b1;
        capture(SLOW + 50, "fast0");
        r1 = rise_tick;
        capture(FAST + 50, "fast1");
        check(rise_tick - r1 == FAST, "R8", "fast interval", rise_tick - r1, FAST);
        r1 = rise_tick;
        capture(FAST + 50, "fast2");
        check(rise_tick - r1 == FAST, "R8", "fast interval repeat", rise_tick - r1, FAST);
        r1 = rise_tick;
        fast_req = 1'b0;
        capture(SLOW + 50, "back");
        check(rise_tick - r1 == SLOW, "R8", "back to slow", rise_tick - r1, SLOW);
    endtask

    task automatic silence_window(input int n, input string tag);
        int act = 0;
        int moves = 0;
        logic m0 = mod_drive;
        for (int i = 0; i < n; i++) begin
            do_tick();
            if (comm_active) act++;
            if (mod_drive !== m0) moves++;
            if (i == n / 2) pulse_ept(8'hEE);
        end
        check(act == 0 && moves == 0, "R10", {tag, " no packet after shutdown"}, act + moves, 0);
        check(busy == 1'b0, "R10", {tag, " busy low in halt"}, busy, 0);
    endtask

    task automatic t_ept_queued();
        int w = 0;
        do_reset();
        while (!comm_active && w < 20) begin do_tick(); w++; end
        repeat (10) do_tick();
        pulse_ept(8'h5A);
        check(comm_active == 1'b1, "R12", "request landed mid-packet", comm_active, 1);
        while (comm_active) do_tick();
        capture(20, "ept_q");
        expect_pkt(8'h02, 1, {56'h0, 8'h5A}, "R12", "queued shutdown next");
        silence_window(SLOW + 200, "queued");
    endtask

    task automatic t_ept_first();
        do_reset();
        pulse_ept(8'h33);
        capture(20, "ept_f");
        expect_pkt(8'h02, 1, {56'h0, 8'h33}, "R9", "shutdown replaces start-up");
        silence_window(300, "first");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_startup_and_slow();
        t_fast();
        t_ept_queued();
        t_ept_first();
        check(quiet_viol == 0, "R11", "line static outside packets", quiet_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule